// File: doc/BRIEF.md
# Load-Use Interlock and Redirect Controller

This block controls stalls and flushes for a five-stage in-order integer pipeline. The stages are fetch, decode, ALU, memory stage one and memory stage two. Each cycle the front end presents a short descriptor for the instruction that sits in decode. The descriptor gives the operation class, the condition outcome, a destination register, two source registers with use flags, and a transfer count. The block decides whether that instruction issues into the ALU stage or holds in decode.

When it holds, the block marks the slot it fills in the ALU stage. That slot is a bubble if the hold comes from a data hazard. It is the instruction's own extra cycle if the instruction takes several cycles. After an instruction that redirects the program counter, the block flushes the two younger slots. Once an instruction has used up all its cycles, the block reports how many cycles it took, counting stall cycles and flush cycles.

Result availability is tracked by time, not by instruction count. A full-word load blocks a consumer in the very next cycle. A narrow (byte or halfword) load also blocks a consumer in the cycle after that, because the extraction stage runs one step later. An instruction that holds in decode must be presented again, unchanged, until the block reports it done.

Top module: `lu_interlock`

## Requirements
- R1: Class codes are: 0 plain ALU (including immediate shifts), 1 ALU with a register-specified shift, 2 word load, 3 narrow load, 4 multi-word load, 5 single store, 6 multi-value store, 7 branch, 8 program-counter write. A plain ALU result feeds the next instruction with no hold, and each such instruction reports 1 cycle.
- R2: A consumer that reads the destination of a word load in the next cycle gets exactly one bubble and reports 2 cycles. One independent instruction in between removes the stall.
- R3: A consumer that reads the destination of a narrow load in the next cycle gets two bubbles and reports 3 cycles. With one independent instruction in between, it gets one bubble and reports 2 cycles. Bubbles never run longer than two in a row.
- R4: A source slot whose use flag is 0 never causes a stall. A load whose condition failed never causes a stall.
- R5: An instruction whose condition flag is 0 reports 1 cycle, with no hold and no flush, whatever its class.
- R6: A register-shifted ALU operation reports 2 cycles and holds decode for 1 of them without a bubble.
- R7: A passing branch, a program-counter write, and a load whose destination is register 15 each assert flush for exactly the two cycles after their last issue cycle. Each reports its issue cycles plus 2.
- R8: A multi-word load of N transfers reports N cycles. Only its final register, given as the destination, delays a consumer, and by one cycle.
- R9: A multi-value store of N values reports N cycles, except that N = 1 reports 2 cycles. A single store reports 1 cycle.
- R10: While flush is asserted, the presented descriptor is ignored. A hazard it would raise asserts neither hold nor bubble.
- R11: During and right after reset, with no valid input, hold, bubble, flush and done are all 0.
- R12: Every bubble coincides with a hold, and done never coincides with a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A descriptor is present in decode |
| in_op | input | 4 | Operation class code (see R1) |
| in_cond | input | 1 | Condition passed (1) or failed (0) |
| in_dst | input | REG_W | Destination register (last register for multi-word loads) |
| in_src_a | input | REG_W | First source register |
| in_use_a | input | 1 | First source slot is used |
| in_src_b | input | REG_W | Second source register |
| in_use_b | input | 1 | Second source slot is used |
| in_xfer | input | CNT_W | Transfer count for multi-word classes (0 treated as 1) |
| hold_o | output | 1 | Decode must hold and present the same descriptor again |
| bubble_o | output | 1 | An empty slot enters the ALU stage this cycle |
| flush_o | output | 1 | Younger wrong-path slots are discarded this cycle |
| done_o | output | 1 | The presented instruction completes its cycles this cycle |
| cycles_o | output | CYC_W | Total cycles of the completing instruction |

## Verification
The bench sweeps every producer class against a dependent consumer. It covers both source slots, an unused slot and an independent reader, with and without a filler instruction in between, and with the producer's condition passing and failing. A design that delayed all loads alike would show one bubble where a narrow load needs two, or miss the stall that is still left after the filler. A design that compared against failed loads or unused slots would insert bubbles that the expected counts do not allow. Separate runs cover transfer counts 1 to 4 for multi-word loads and stores, where the single-value store is the odd case. They also check that a dependent wrong-path descriptor shown during a flush window causes no hold: a design that let a stall win over the flush would stretch the branch beyond 3 cycles.

// File: rtl/lu_pkg.sv
package lu_pkg;
    typedef enum logic [3:0] {
        OP_ALU    = 4'd0,
        OP_ALU_RS = 4'd1,
        OP_LDW    = 4'd2,
        OP_LDB    = 4'd3,
        OP_LDM    = 4'd4,
        OP_STR    = 4'd5,
        OP_STM    = 4'd6,
        OP_BR     = 4'd7,
        OP_PCW    = 4'd8
    } op_e;

    // age slots after the issue edge: memory stage 1 and memory stage 2
    localparam int TRK_DEPTH = 2;
    // slots discarded after a redirecting instruction
    localparam int REDIR_CYC = 2;
endpackage

// File: rtl/lu_cost.sv
module lu_cost
    import lu_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int CNT_W  = 5,
    parameter int PC_IDX = 15
) (
    input  logic [3:0]       op,
    input  logic [CNT_W-1:0] xfer,
    input  logic [REG_W-1:0] dst,
    output logic [CNT_W:0]   len,
    output logic             is_load,
    output logic             narrow,
    output logic             redirect
);
    logic [CNT_W:0] n;

    always_comb begin
        n        = (xfer == '0) ? (CNT_W+1)'(1) : {1'b0, xfer};
        len      = (CNT_W+1)'(1);
        is_load  = 1'b0;
        narrow   = 1'b0;
        case (op_e'(op))
            OP_ALU_RS: len = (CNT_W+1)'(2);
            OP_LDW:    is_load = 1'b1;
            OP_LDB:    begin is_load = 1'b1; narrow = 1'b1; end
            OP_LDM:    begin is_load = 1'b1; len = n; end
            OP_STM:    len = (n == (CNT_W+1)'(1)) ? (CNT_W+1)'(2) : n;
            default:   len = (CNT_W+1)'(1);
        endcase
        redirect = (op_e'(op) == OP_BR) || (op_e'(op) == OP_PCW) ||
                   (is_load && dst == REG_W'(PC_IDX));
    end
endmodule

// File: rtl/lu_hazard.sv
module lu_hazard #(
    parameter int REG_W = 4,
    parameter int DEPTH = 2
) (
    input  logic [REG_W-1:0]       src_a,
    input  logic                   use_a,
    input  logic [REG_W-1:0]       src_b,
    input  logic                   use_b,
    input  logic [DEPTH-1:0]       pend_v,
    input  logic [DEPTH-1:0]       pend_n,
    input  logic [DEPTH*REG_W-1:0] pend_d,
    output logic                   hit
);
    logic [DEPTH-1:0] blk;

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [REG_W-1:0] rd;
        logic             match;
        assign rd    = pend_d[k*REG_W +: REG_W];
        assign match = (use_a && src_a == rd) || (use_b && src_b == rd);
        if (k == 0) begin : g_near
            // every load is still unavailable one slot after issue
            assign blk[k] = pend_v[k] && match;
        end else begin : g_far
            // only narrow loads remain unavailable further out
            assign blk[k] = pend_v[k] && pend_n[k] && match;
        end
    end

    assign hit = |blk;
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
    import lu_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int CNT_W  = 5,
    parameter int CYC_W  = 8,
    parameter int PC_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic             in_cond,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic             in_use_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic             in_use_b,
    input  logic [CNT_W-1:0] in_xfer,
    output logic             hold_o,
    output logic             bubble_o,
    output logic             flush_o,
    output logic             done_o,
    output logic [CYC_W-1:0] cycles_o
);
    localparam int FL_W = $clog2(REDIR_CYC + 1);

    typedef struct packed {
        logic                       busy;
        logic [CNT_W:0]             remain;
        logic [CYC_W-1:0]           acc;
        logic [FL_W-1:0]            flush;
        logic [TRK_DEPTH-1:0]       pv;
        logic [TRK_DEPTH-1:0]       pn;
        logic [TRK_DEPTH*REG_W-1:0] pd;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W:0]   len;
    logic             is_load, narrow, redirect, hit;
    logic [CNT_W:0]   rem;
    logic [CYC_W-1:0] acc_inc;

    lu_cost #(.REG_W(REG_W), .CNT_W(CNT_W), .PC_IDX(PC_IDX)) u_cost (
        .op(in_op), .xfer(in_xfer), .dst(in_dst),
        .len(len), .is_load(is_load), .narrow(narrow), .redirect(redirect)
    );

    lu_hazard #(.REG_W(REG_W), .DEPTH(TRK_DEPTH)) u_haz (
        .src_a(in_src_a), .use_a(in_use_a), .src_b(in_src_b), .use_b(in_use_b),
        .pend_v(st_q.pv), .pend_n(st_q.pn), .pend_d(st_q.pd), .hit(hit)
    );

    always_comb begin
        st_d     = st_q;
        hold_o   = 1'b0;
        bubble_o = 1'b0;
        flush_o  = 1'b0;
        done_o   = 1'b0;
        cycles_o = '0;
        acc_inc  = st_q.acc + CYC_W'(1);
        rem      = st_q.busy ? st_q.remain : len - (CNT_W+1)'(1);

        // load results age by time, stalls included
        st_d.pv[0] = 1'b0;
        st_d.pn[0] = 1'b0;
        st_d.pd[REG_W-1:0] = '0;
        for (int k = 1; k < TRK_DEPTH; k++) begin
            st_d.pv[k] = st_q.pv[k-1];
            st_d.pn[k] = st_q.pn[k-1];
            st_d.pd[k*REG_W +: REG_W] = st_q.pd[(k-1)*REG_W +: REG_W];
        end

        if (st_q.flush != '0) begin
            // wrong-path slot: descriptor and its hazards are ignored
            flush_o    = 1'b1;
            st_d.flush = st_q.flush - FL_W'(1);
            if (st_q.flush == FL_W'(1)) begin
                done_o   = 1'b1;
                cycles_o = acc_inc;
                st_d.acc = '0;
            end else begin
                st_d.acc = acc_inc;
            end
        end else if (in_valid) begin
            if (!in_cond) begin
                done_o   = 1'b1;
                cycles_o = CYC_W'(1);
                st_d.acc = '0;
            end else if (!st_q.busy && hit) begin
                hold_o   = 1'b1;
                bubble_o = 1'b1;
                st_d.acc = acc_inc;
            end else if (rem != '0) begin
                hold_o      = 1'b1;
                st_d.busy   = 1'b1;
                st_d.remain = rem - (CNT_W+1)'(1);
                st_d.acc    = acc_inc;
            end else begin
                st_d.busy   = 1'b0;
                st_d.remain = '0;
                if (is_load && !redirect) begin
                    st_d.pv[0]         = 1'b1;
                    st_d.pn[0]         = narrow;
                    st_d.pd[REG_W-1:0] = in_dst;
                end
                if (redirect) begin
                    st_d.flush = FL_W'(REDIR_CYC);
                    st_d.acc   = acc_inc;
                end else begin
                    done_o   = 1'b1;
                    cycles_o = acc_inc;
                    st_d.acc = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
    parameter int CYC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_cond,
    input logic             hold_o,
    input logic             bubble_o,
    input logic             flush_o,
    input logic             done_o,
    input logic [CYC_W-1:0] cycles_o
);
    AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> hold_o); // R12
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !hold_o); // R12
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (!hold_o && !bubble_o)); // R10
    AST_FLUSH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_o) |=> flush_o); // R7
    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && $past(flush_o)) |=> !flush_o); // R7
    AST_BUBBLE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble_o && $past(bubble_o)) |=> !bubble_o); // R3
    AST_CONDFAIL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cond && !flush_o) |-> (done_o && cycles_o == CYC_W'(1))); // R5
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o != '0)); // R12
endmodule

bind lu_interlock lu_interlock_chk #(.CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
    .hold_o(hold_o), .bubble_o(bubble_o), .flush_o(flush_o),
    .done_o(done_o), .cycles_o(cycles_o)
);

// File: tb/lu_interlock_tb.sv
`timescale 1ns/1ps
module lu_interlock_tb;
    localparam int REG_W = 4;
    localparam int CNT_W = 5;
    localparam int CYC_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] in_op = '0;
    logic in_cond = 1'b0;
    logic [REG_W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic in_use_a = 1'b0, in_use_b = 1'b0;
    logic [CNT_W-1:0] in_xfer = '0;
    logic hold_o, bubble_o, flush_o, done_o;
    logic [CYC_W-1:0] cycles_o;

    int errors = 0;
    int checks = 0;

    // wrong-path descriptor shown during a flush window
    logic wp_valid = 1'b0;
    logic [REG_W-1:0] wp_src = '0;

    always #10 clk = ~clk;

    lu_interlock #(.REG_W(REG_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cond(in_cond), .in_dst(in_dst), .in_src_a(in_src_a),
        .in_use_a(in_use_a), .in_src_b(in_src_b), .in_use_b(in_use_b),
        .in_xfer(in_xfer), .hold_o(hold_o), .bubble_o(bubble_o),
        .flush_o(flush_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // present one instruction until it reports done
    task automatic run(input int op, input logic cond, input int dst,
                       input int sa, input logic ua, input int sb, input logic ub,
                       input int n, output int cyc, output int bub,
                       output int fl, output int holds);
        bit sw = 0;
        cyc = 0; bub = 0; fl = 0; holds = 0;
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (g == 0 || !sw) begin
                in_valid = 1'b1; in_op = 4'(op); in_cond = cond;
                in_dst = REG_W'(dst); in_src_a = REG_W'(sa); in_use_a = ua;
                in_src_b = REG_W'(sb); in_use_b = ub; in_xfer = CNT_W'(n);
            end else begin
                in_valid = wp_valid; in_op = 4'd0; in_cond = 1'b1;
                in_dst = REG_W'(1); in_src_a = wp_src; in_use_a = 1'b1;
                in_use_b = 1'b0;
            end
            #1;
            if (bubble_o) bub++;
            if (flush_o) fl++;
            if (hold_o) holds++;
            if (done_o) begin
                cyc = int'(cycles_o);
                break;
            end
            if (!hold_o && !flush_o) sw = 1;
            if (g == 39) chk("R12", "instruction never completed", 0, 1);
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int k);
        in_valid = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    function automatic int base_cost(input int op, input int n);
        int nn = (n == 0) ? 1 : n;
        case (op)
            1: return 2;
            4: return nn;
            6: return (nn == 1) ? 2 : nn;
            7, 8: return 3;
            default: return 1;
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        chk("R12", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c, b, f, h;
        int prods[6] = '{0, 1, 2, 3, 4, 5};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "hold in reset", int'(hold_o), 0);
        chk("R11", "flush in reset", int'(flush_o), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11", "bubble after reset", int'(bubble_o), 0);
        chk("R11", "done after reset", int'(done_o), 0);

        // producer x gap x dependence x condition sweep (R1 R2 R3 R4)
        foreach (prods[i]) begin
            for (int gap = 0; gap < 2; gap++) begin
                for (int dep = 0; dep < 4; dep++) begin
                    for (int cp = 0; cp < 2; cp++) begin
                        int op = prods[i];
                        int n = (op == 4) ? 3 : 1;
                        int stall = 0;
                        bit ld = (op == 2 || op == 3 || op == 4);
                        if (cp == 1 && dep < 2 && ld) begin
                            if (op == 3) stall = (gap == 0) ? 2 : 1;
                            else stall = (gap == 0) ? 1 : 0;
                        end
                        run(op, cp[0], 2, 3, 1'b1, 4, 1'b0, n, c, b, f, h);
                        chk("R1", "producer cycles", c, (cp == 1) ? base_cost(op, n) : 1);
                        if (gap == 1) begin
                            run(0, 1'b1, 9, 10, 1'b1, 11, 1'b1, 0, c, b, f, h);
                            chk("R3", "filler cycles", c, 1);
                        end
                        run(0, 1'b1, 7,
                            (dep == 0 || dep == 2) ? 2 : 5, dep != 2,
                            (dep == 1) ? 2 : 6, dep == 1, 0, c, b, f, h);
                        // R2 R3 R4: consumer cost and bubbles
                        chk(op == 3 ? "R3" : (dep >= 2 || cp == 0) ? "R4" : "R2",
                            "consumer cycles", c, 1 + stall);
                        chk(op == 3 ? "R3" : "R2", "consumer bubbles", b, stall);
                        idle(3);
                    end
                end
            end
        end

        // R8 multi-word load, R9 multi-value store
        for (int n = 1; n <= 4; n++) begin
            run(4, 1'b1, 8, 3, 1'b1, 4, 1'b0, n, c, b, f, h);
            chk("R8", "multi-load cycles", c, n);
            run(0, 1'b1, 7, 8, 1'b1, 0, 1'b0, 0, c, b, f, h);
            chk("R8", "multi-load consumer bubbles", b, 1);
            run(6, 1'b1, 0, 3, 1'b1, 4, 1'b1, n, c, b, f, h);
            chk("R9", "multi-store cycles", c, (n == 1) ? 2 : n);
            chk("R9", "multi-store bubbles", b, 0);
        end
        run(5, 1'b1, 0, 3, 1'b1, 4, 1'b1, 0, c, b, f, h);
        chk("R9", "single store cycles", c, 1);

        // R6 register-specified shift
        run(1, 1'b1, 3, 4, 1'b1, 5, 1'b1, 0, c, b, f, h);
        chk("R6", "reg-shift cycles", c, 2);
        chk("R6", "reg-shift holds", h, 1);
        chk("R6", "reg-shift bubbles", b, 0);

        // R7 redirects
        run(7, 1'b1, 0, 0, 1'b0, 0, 1'b0, 0, c, b, f, h);
        chk("R7", "branch cycles", c, 3);
        chk("R7", "branch flush cycles", f, 2);
        run(8, 1'b1, 15, 1, 1'b1, 2, 1'b0, 0, c, b, f, h);
        chk("R7", "pc write cycles", c, 3);
        chk("R7", "pc write flush cycles", f, 2);
        run(2, 1'b1, 15, 1, 1'b1, 2, 1'b0, 0, c, b, f, h);
        chk("R7", "pc load cycles", c, 3);
        chk("R7", "pc load flush cycles", f, 2);
        run(4, 1'b1, 15, 1, 1'b1, 2, 1'b0, 2, c, b, f, h);
        chk("R7", "pc multi-load cycles", c, 4);

        // R5 failed branch does not redirect
        run(7, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, c, b, f, h);
        chk("R5", "failed branch cycles", c, 1);
        chk("R5", "failed branch flush", f, 0);
        run(6, 1'b0, 0, 1, 1'b1, 2, 1'b1, 4, c, b, f, h);
        chk("R5", "failed multi-store cycles", c, 1);
        idle(3);

        // R10 dependent wrong-path descriptor during flush
        run(3, 1'b1, 5, 1, 1'b1, 2, 1'b0, 0, c, b, f, h);
        wp_valid = 1'b1; wp_src = REG_W'(5);
        run(7, 1'b1, 0, 0, 1'b0, 0, 1'b0, 0, c, b, f, h);
        wp_valid = 1'b0;
        chk("R10", "branch cycles with wrong-path hazard", c, 3);
        chk("R10", "bubbles during flush", b, 0);
        chk("R10", "holds during flush", h, 0);
        idle(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule